// File: doc/BRIEF.md
# Completion Fence Pending-Operation Tracker

This block keeps a per-level tally of cache-maintenance operations that have been issued into the memory hierarchy but not yet acknowledged. Each supported hierarchy level (for example battery-backed memory, first commit to non-volatile storage, redundant non-volatile commit) owns one saturating counter. An issue event for a level increments its counter and a completion event decrements it.

A completion fence names a target level. The fence blocks, holding a stall output high, until the counters for that level and every nearer level read zero. It then emits a one-cycle done pulse. The fence looks only at the level field. The operation kind that accompanies issue events and fence requests is ignored, so writebacks and invalidates are treated alike. Ordinary stores are visible on an input but never counted. A fence aimed at a level the implementation does not support finishes at once and flags an error. No progress value is returned.

Top module: `cft_top`

## Requirements
- R1: After synchronous reset, `fence_done`, `fence_stall` and `fence_err` are low and every level counter is zero.
- R2: A fence request arriving while idle, with the counters of levels 0..L all zero, raises `fence_done` in the cycle after the request and never raises `fence_stall`.
- R3: A fence request while any counter in levels 0..L is non-zero raises `fence_stall` in the cycle after the request. The stall holds until those counters are zero, and `fence_done` rises (with stall falling) one cycle after the cycle in which the last of them becomes zero.
- R4: Pending operations on levels above L do not delay a fence to level L.
- R5: The operation-kind inputs (`mo_issue_kind`, `fence_kind`) have no effect. Kind 0 (writeback) and kind 1 (invalidate) issues are both counted, and a fence behaves the same for any kind value.
- R6: `store_vld` has no effect on any counter or fence result.
- R7: An issue and a completion on the same level in the same cycle leave that level's count unchanged.
- R8: A level counter saturates at 2^CNT_W-1. Further issues are dropped, so that many completions empty it.
- R9: A completion on a level whose count is zero is ignored. The count does not wrap.
- R10: A fence to a level index of NUM_LEVELS or more raises `fence_done` and `fence_err` together in the next cycle, whatever is pending. Issues and completions naming such a level are ignored.
- R11: Issue events arriving while a fence stalls are counted, and the fence also waits for them when they target levels 0..L.
- R12: Fence requests arriving while `fence_stall` is high are ignored.
- R13: `fence_done` and `fence_err` are single-cycle pulses per accepted fence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mo_issue | input | 1 | A maintenance operation is issued this cycle |
| mo_issue_lvl | input | LVL_W | Target level of the issued operation |
| mo_issue_kind | input | KIND_W | Operation kind of the issue (ignored) |
| mo_done | input | 1 | A maintenance operation completes this cycle |
| mo_done_lvl | input | LVL_W | Level of the completing operation |
| store_vld | input | 1 | Ordinary store seen this cycle (ignored) |
| fence_req | input | 1 | Completion fence request |
| fence_lvl | input | LVL_W | Level the fence must reach |
| fence_kind | input | KIND_W | Operation field of the fence specifier (ignored) |
| fence_done | output | 1 | One-cycle pulse: fence finished |
| fence_stall | output | 1 | Fence is waiting on pending operations |
| fence_err | output | 1 | One-cycle pulse with done: unsupported level |

## Verification
Every output is registered. A fence that needs no wait shows done (and err, if unsupported) one clock after the request edge. A waiting fence shows stall one clock after the request and done two clocks after the completion edge that empties its levels: one edge updates the counter and the next edge checks it. The bench drives and samples on the falling edge and steps a fixed number of falling edges per stimulus to match these latencies. It therefore checks the exact cycle and also the cycle before, where the result must not yet appear.

// File: rtl/cft_pkg.sv
package cft_pkg;
  typedef enum logic [0:0] {
    FS_IDLE = 1'b0,
    FS_WAIT = 1'b1
  } fence_state_t;
endpackage

// File: rtl/cft_level_cnt.sv
module cft_level_cnt #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic dec,
  output logic is_zero
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else begin
      unique case ({inc, dec})
        2'b10:   if (cnt != CMAX) cnt <= cnt + 1'b1;
        2'b01:   if (cnt != '0)   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign is_zero = (cnt == '0);

  // R8
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == CMAX && inc && !dec) |=> (cnt == CMAX));
  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && dec && !inc) |=> (cnt == '0));
  // R7
  same_cycle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && dec) |=> $stable(cnt));
endmodule

// File: rtl/cft_prefix_clear.sv
module cft_prefix_clear #(
  parameter int NUM_LEVELS = 4,
  parameter int PAD_W      = 4
) (
  input  logic [NUM_LEVELS-1:0] lvl_zero,
  output logic [PAD_W-1:0]      upto_clear
);
  genvar g;
  generate
    for (g = 0; g < PAD_W; g++) begin : g_pfx
      if (g == 0) begin : g_first
        assign upto_clear[g] = lvl_zero[0];
      end else if (g < NUM_LEVELS) begin : g_mid
        assign upto_clear[g] = upto_clear[g-1] & lvl_zero[g];
      end else begin : g_pad
        assign upto_clear[g] = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/cft_fence_fsm.sv
module cft_fence_fsm
  import cft_pkg::*;
#(
  parameter int LVL_W      = 3,
  parameter int NUM_LEVELS = 4,
  parameter int IDX_W      = 2,
  parameter int PAD_W      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [LVL_W-1:0] req_lvl,
  input  logic [PAD_W-1:0] upto_clear,
  output logic             done,
  output logic             stall,
  output logic             err
);
  fence_state_t     state;
  logic [IDX_W-1:0] lvl_q;
  logic             req_ok;
  logic [IDX_W-1:0] req_idx;

  assign req_ok  = (req_lvl < LVL_W'(NUM_LEVELS));
  assign req_idx = req_lvl[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= FS_IDLE;
      lvl_q <= '0;
      done  <= 1'b0;
      stall <= 1'b0;
      err   <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (state)
        FS_IDLE: begin
          if (req) begin
            if (!req_ok) begin
              done <= 1'b1;
              err  <= 1'b1;
            end else if (upto_clear[req_idx]) begin
              done <= 1'b1;
            end else begin
              state <= FS_WAIT;
              lvl_q <= req_idx;
              stall <= 1'b1;
            end
          end
        end
        FS_WAIT: begin
          if (upto_clear[lvl_q]) begin
            state <= FS_IDLE;
            stall <= 1'b0;
            done  <= 1'b1;
          end
        end
        default: state <= FS_IDLE;
      endcase
    end
  end

  // R10
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> done);
  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stall && !upto_clear[lvl_q]) |=> (stall && !done));
  // R3
  stall_release_chk: assert property (@(posedge clk) disable iff (rst)
    (stall && upto_clear[lvl_q]) |=> (done && !stall));
  // R12
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (stall && req && !upto_clear[lvl_q]) |=> !err);
  // R13
  done_stall_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && stall));
endmodule

// File: rtl/cft_top.sv
module cft_top #(
  parameter int NUM_LEVELS = 4,
  parameter int LVL_W      = 3,
  parameter int KIND_W     = 3,
  parameter int CNT_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mo_issue,
  input  logic [LVL_W-1:0]  mo_issue_lvl,
  input  logic [KIND_W-1:0] mo_issue_kind,
  input  logic              mo_done,
  input  logic [LVL_W-1:0]  mo_done_lvl,
  input  logic              store_vld,
  input  logic              fence_req,
  input  logic [LVL_W-1:0]  fence_lvl,
  input  logic [KIND_W-1:0] fence_kind,
  output logic              fence_done,
  output logic              fence_stall,
  output logic              fence_err
);
  localparam int IDX_W = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1;
  localparam int PAD_W = 1 << IDX_W;

  logic [NUM_LEVELS-1:0] lvl_zero;
  logic [NUM_LEVELS-1:0] lvl_inc;
  logic [NUM_LEVELS-1:0] lvl_dec;
  logic [PAD_W-1:0]      upto_clear;

  // Kind fields and plain stores do not take part in fencing.
  logic unused_inputs;
  assign unused_inputs = ^{mo_issue_kind, fence_kind, store_vld};

  genvar g;
  generate
    for (g = 0; g < NUM_LEVELS; g++) begin : g_lvl
      assign lvl_inc[g] = mo_issue && (mo_issue_lvl == LVL_W'(g));
      assign lvl_dec[g] = mo_done  && (mo_done_lvl  == LVL_W'(g));
      cft_level_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .inc     (lvl_inc[g]),
        .dec     (lvl_dec[g]),
        .is_zero (lvl_zero[g])
      );
    end
  endgenerate

  cft_prefix_clear #(.NUM_LEVELS(NUM_LEVELS), .PAD_W(PAD_W)) u_pfx (
    .lvl_zero   (lvl_zero),
    .upto_clear (upto_clear)
  );

  cft_fence_fsm #(
    .LVL_W(LVL_W), .NUM_LEVELS(NUM_LEVELS), .IDX_W(IDX_W), .PAD_W(PAD_W)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req        (fence_req),
    .req_lvl    (fence_lvl),
    .upto_clear (upto_clear),
    .done       (fence_done),
    .stall      (fence_stall),
    .err        (fence_err)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!fence_done && !fence_stall && !fence_err));
  // R2
  idle_clear_done_chk: assert property (@(posedge clk) disable iff (rst)
    (fence_req && !fence_stall && fence_lvl < LVL_W'(NUM_LEVELS)
     && upto_clear[fence_lvl[IDX_W-1:0]]) |=> (fence_done && !fence_stall));
endmodule

// File: tb/sim_cft_top.sv
module sim_cft_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       mo_issue, mo_done, store_vld, fence_req;
  logic [2:0] mo_issue_lvl, mo_done_lvl, fence_lvl;
  logic [2:0] mo_issue_kind, fence_kind;
  logic       fence_done, fence_stall, fence_err;

  int n_run  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  cft_top u0 (
    .clk(clk), .rst(rst),
    .mo_issue(mo_issue), .mo_issue_lvl(mo_issue_lvl), .mo_issue_kind(mo_issue_kind),
    .mo_done(mo_done), .mo_done_lvl(mo_done_lvl), .store_vld(store_vld),
    .fence_req(fence_req), .fence_lvl(fence_lvl), .fence_kind(fence_kind),
    .fence_done(fence_done), .fence_stall(fence_stall), .fence_err(fence_err)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [2:0] act, logic [2:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got done/stall/err=%b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] outs();
    return {fence_done, fence_stall, fence_err};
  endfunction

  task automatic issue(logic [2:0] lvl, logic [2:0] kind);
    mo_issue = 1'b1; mo_issue_lvl = lvl; mo_issue_kind = kind;
    tick();
    mo_issue = 1'b0;
  endtask

  task automatic complete(logic [2:0] lvl);
    mo_done = 1'b1; mo_done_lvl = lvl;
    tick();
    mo_done = 1'b0;
  endtask

  task automatic fence(logic [2:0] lvl, logic [2:0] kind);
    fence_req = 1'b1; fence_lvl = lvl; fence_kind = kind;
    tick();
    fence_req = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    mo_issue = 0; mo_done = 0; store_vld = 0; fence_req = 0;
    mo_issue_lvl = 0; mo_done_lvl = 0; fence_lvl = 0;
    mo_issue_kind = 0; fence_kind = 0;
    tick(); tick();
    rst = 1'b0;
    chk("R1 reset outputs", outs(), 3'b000);
    fence(3'd3, 3'd0);
    chk("R1 counts zero after reset", outs(), 3'b100);
    tick();
  endtask

  task automatic t_idle_fence();
    fence(3'd2, 3'd4);
    chk("R2 immediate done", outs(), 3'b100);
    tick();
    chk("R13 done is one pulse", outs(), 3'b000);
  endtask

  task automatic t_wait_both_kinds();
    issue(3'd1, 3'd0);
    issue(3'd1, 3'd1);
    fence(3'd2, 3'd0);
    chk("R3 stall after request", outs(), 3'b010);
    complete(3'd1);
    chk("R5 invalidate still pending", outs(), 3'b010);
    complete(3'd1);
    chk("R3 not done on emptying edge", outs(), 3'b010);
    tick();
    chk("R3 done after last completion", outs(), 3'b100);
    tick();
    chk("R13 single done pulse", outs(), 3'b000);
  endtask

  task automatic t_higher_level();
    issue(3'd2, 3'd2);
    fence(3'd0, 3'd0);
    chk("R4 deeper level not waited", outs(), 3'b100);
    fence(3'd1, 3'd6);
    chk("R5 fence kind ignored", outs(), 3'b100);
    complete(3'd2);
    tick();
  endtask

  task automatic t_store();
    store_vld = 1'b1;
    tick(); tick();
    fence(3'd3, 3'd0);
    store_vld = 1'b0;
    chk("R6 stores not waited", outs(), 3'b100);
    tick();
  endtask

  task automatic t_same_cycle();
    issue(3'd0, 3'd0);
    mo_issue = 1; mo_issue_lvl = 0; mo_done = 1; mo_done_lvl = 0;
    tick();
    mo_issue = 0; mo_done = 0;
    fence(3'd0, 3'd0);
    chk("R7 count unchanged", outs(), 3'b010);
    complete(3'd0);
    tick();
    chk("R7 one completion drains", outs(), 3'b100);
    tick();
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 20; i++) issue(3'd3, 3'd1);
    for (int i = 0; i < 14; i++) complete(3'd3);
    fence(3'd3, 3'd0);
    chk("R8 one left after 14", outs(), 3'b010);
    complete(3'd3);
    tick();
    chk("R8 saturated at 15", outs(), 3'b100);
    tick();
  endtask

  task automatic t_underflow();
    complete(3'd1);
    complete(3'd1);
    issue(3'd1, 3'd0);
    fence(3'd1, 3'd0);
    chk("R9 no wrap below zero", outs(), 3'b010);
    complete(3'd1);
    tick();
    chk("R9 drains normally", outs(), 3'b100);
    tick();
  endtask

  task automatic t_unsupported();
    issue(3'd0, 3'd0);
    issue(3'd5, 3'd0);
    fence(3'd5, 3'd0);
    chk("R10 immediate error", outs(), 3'b101);
    tick();
    chk("R13 error is one pulse", outs(), 3'b000);
    complete(3'd0);
    fence(3'd3, 3'd0);
    chk("R10 bad-level issue ignored", outs(), 3'b100);
    tick();
  endtask

  task automatic t_issue_while_stalled();
    issue(3'd0, 3'd0);
    fence(3'd1, 3'd0);
    chk("R11 stall", outs(), 3'b010);
    issue(3'd1, 3'd0);
    complete(3'd0);
    tick();
    chk("R11 new issue still waited", outs(), 3'b010);
    fence_req = 1; fence_lvl = 3'd7;
    tick();
    fence_req = 0;
    chk("R12 request while busy ignored", outs(), 3'b010);
    complete(3'd1);
    tick();
    chk("R11 done after both", outs(), 3'b100);
    tick();
    chk("R12 no late error", outs(), 3'b000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_idle_fence();
    t_wait_both_kinds();
    t_higher_level();
    t_store();
    t_same_cycle();
    t_saturate();
    t_underflow();
    t_unsupported();
    t_issue_while_stalled();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule